// File: doc/BRIEF.md
# GPIO Controller with Edge Interrupts

A thirteen-pin general-purpose I/O controller behind a byte-wide register bus. Every pin has two private registers. The drive register sets the pin's direction, its drive type, its pull request and its output level. The sense register selects which edges of the pin raise an interrupt, and it also reports the pin's synchronized level. The pins are grouped in banks of seven (pins 0–6), four (pins 7–10) and two (pins 11–12).

Detected edges are latched into two status registers. One covers pins 0–6 and the other covers pins 7–12. Each status register has a companion mask register. A single level interrupt stays high while any latched, unmasked status bit is set. Software clears status bits by writing ones to them. The pull fields are not acted on inside the block: they are only brought out as control outputs for the pad ring.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, every drive and sense register is 0, both status registers read 0, the mask registers read 0x7f (group A) and 0x3f (group B), `irq` is 0 and no pin drives.
- R2: The drive register of pin i is at address 0x00+i (i = 0..12) and reads back the six bits written to it. In that register, bit 5 sets the direction (1 = output), bit 4 sets the drive type (1 = push-pull, 0 = open-drain), bit 3 enables the pull and bit 0 is the output level.
- R3: `pin_out[i]` always equals bit 0. `pin_oe[i]` is 0 when the pin is an input. For an output pin, `pin_oe[i]` is 1 in push-pull mode, and in open-drain mode it is the inverse of bit 0.
- R4: `pull_en[i]` equals bit 3 of the drive register. `pull_sel[2i+1:2i]` equals bits 2:1 of that register (00 = 2k down, 01 = 2k up, 10 = 50k down, 11 = 50k up).
- R5: The sense register of pin i is at address 0x10+i. Bits 2:1 hold the edge mode, and bit 0 reads the pin level after a two-flop synchronizer.
- R6: The edge mode selects which edges are captured: 00 = none, 01 = falling, 10 = rising, 11 = both. A captured edge sets status bit i of group A (address 0x20) for pins 0–6, or bit i-7 of group B (address 0x21) for pins 7–12. The status bit is set on the third clock edge after the pin changes.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. Status bits never clear without a write.
- R8: If a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: The mask registers are at 0x28 (group A) and 0x29 (group B). A mask bit of 1 blocks its pin. `irq` is 1 exactly when some status bit is set while its mask bit is 0.
- R10: The unused upper bits of the status and mask registers read as 0, even after a write of ones.
- R11: Reads of unmapped addresses return 0, and writes to unmapped addresses change no register.
- R12: `rdata` is loaded on the clock edge where `rd_en` is 1, and it holds its value while `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pin_in | input | 13 | Asynchronous pin levels |
| pin_out | output | 13 | Output level per pin |
| pin_oe | output | 13 | Output enable per pin |
| pull_en | output | 13 | Pull enable per pin |
| pull_sel | output | 26 | Two-bit pull selection per pin |
| irq | output | 1 | Level interrupt |

## Verification
Every pin is run through all four edge modes, with one rising and one falling transition in each mode. A status bit that is set by the wrong edge, in the wrong group or at the wrong bit position therefore shows up as a mismatch. All 64 values of each drive register are applied, which covers every combination of direction, drive type and level, so the output-enable rule is checked in full. Further directed cases target the narrow corners: an edge arriving in the same cycle as a clearing write, masking a status bit that is already set, writes of ones to the unused status and mask bits, and accesses to unmapped addresses.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NPINS = 13,
  parameter int GA_PINS = 7,
  parameter int AW = 8,
  parameter logic [AW-1:0] DRV_BASE = 'h00,
  parameter logic [AW-1:0] SNS_BASE = 'h10,
  parameter logic [AW-1:0] STAT_BASE = 'h20,
  parameter logic [AW-1:0] MASK_BASE = 'h28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [7:0]         rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pull_en,
  output logic [2*NPINS-1:0] pull_sel,
  output logic               irq
);
  localparam int GB_PINS = NPINS - GA_PINS;
  localparam logic [AW-1:0] STAT_B = STAT_BASE + AW'(1);
  localparam logic [AW-1:0] MASK_B = MASK_BASE + AW'(1);

  logic [5:0] drv [NPINS];
  logic [1:0] mode [NPINS];
  logic [NPINS-1:0] sync1, sync2, lvl_d, status, mask, dir_vec, edge_hit, clr;
  logic [7:0] rd_mux;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_out[i] = drv[i][0];
    assign dir_vec[i] = drv[i][5];
    assign pin_oe[i]  = drv[i][5] & (drv[i][4] | ~drv[i][0]);
    assign pull_en[i] = drv[i][3];
    assign pull_sel[2*i +: 2] = drv[i][2:1];
    assign edge_hit[i] = (mode[i][1] & sync2[i] & ~lvl_d[i]) |
                         (mode[i][0] & ~sync2[i] & lvl_d[i]);
  end

  always_comb begin
    clr = '0;
    if (wr_en && addr == STAT_BASE) clr[GA_PINS-1:0] = wdata[GA_PINS-1:0];
    if (wr_en && addr == STAT_B)    clr[NPINS-1:GA_PINS] = wdata[GB_PINS-1:0];
  end

  assign irq = |(status & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      lvl_d  <= '0;
      status <= '0;
      mask   <= '1;
      for (int i = 0; i < NPINS; i++) begin
        drv[i]  <= '0;
        mode[i] <= '0;
      end
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      lvl_d  <= sync2;
      status <= (status & ~clr) | edge_hit;
      if (wr_en && addr == MASK_BASE) mask[GA_PINS-1:0] <= wdata[GA_PINS-1:0];
      if (wr_en && addr == MASK_B)    mask[NPINS-1:GA_PINS] <= wdata[GB_PINS-1:0];
      for (int i = 0; i < NPINS; i++) begin
        if (wr_en && addr == DRV_BASE + AW'(i)) drv[i]  <= wdata[5:0];
        if (wr_en && addr == SNS_BASE + AW'(i)) mode[i] <= wdata[2:1];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (addr == DRV_BASE + AW'(i)) rd_mux = {2'b00, drv[i]};
      if (addr == SNS_BASE + AW'(i)) rd_mux = {5'b00000, mode[i], sync2[i]};
    end
    if (addr == STAT_BASE) rd_mux = 8'(status[GA_PINS-1:0]);
    if (addr == STAT_B)    rd_mux = 8'(status[NPINS-1:GA_PINS]);
    if (addr == MASK_BASE) rd_mux = 8'(mask[GA_PINS-1:0]);
    if (addr == MASK_B)    rd_mux = 8'(mask[NPINS-1:GA_PINS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

module gpio_edge_ctrl_chk #(
  parameter int NPINS = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] dir_vec,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] sync2,
  input logic [NPINS-1:0] lvl_d
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  assert_no_drive_as_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_vec) == '0);

  assert_edge_needs_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == lvl_d) |=> ((status & ~$past(status)) == '0));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((status & $past(status)) == $past(status)));

  assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != '0));
endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq), .pin_oe(pin_oe),
  .dir_vec(dir_vec), .status(status), .sync2(sync2), .lvl_d(lvl_d)
);

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
  localparam logic [7:0] DRV = 8'h00, SNS = 8'h10, STA = 8'h20, STB = 8'h21, MKA = 8'h28, MKB = 8'h29;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [12:0] pin_in = 0, pin_out, pin_oe, pull_en;
  logic [25:0] pull_sel;
  int vecs = 0, errs = 0;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_en(pull_en), .pull_sel(pull_sel), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pin_oe", int'(pin_oe), 0);
    rd(MKA, d); chk("R1 mask A", d, 8'h7f);
    rd(MKB, d); chk("R1 mask B", d, 8'h3f);
    rd(STA, d); chk("R1 status A", d, 0);
    rd(STB, d); chk("R1 status B", d, 0);
    for (int i = 0; i < 13; i++) begin
      rd(DRV + 8'(i), d); chk("R1 drive reg", d, 0);
      rd(SNS + 8'(i), d); chk("R1 sense reg", d, 0);
    end

    // R2 R3 R4: full drive-register sweep
    for (int i = 0; i < 13; i++) begin
      for (int v = 0; v < 64; v++) begin
        logic [5:0] b;
        b = 6'(v);
        wr(DRV + 8'(i), 8'(v));
        chk("R3 pin_out", int'(pin_out[i]), int'(b[0]));
        chk("R3 pin_oe", int'(pin_oe[i]), int'(b[5] & (b[4] | ~b[0])));
        chk("R4 pull_en", int'(pull_en[i]), int'(b[3]));
        chk("R4 pull_sel", int'(pull_sel[2*i +: 2]), int'(b[2:1]));
        rd(DRV + 8'(i), d); chk("R2 readback", d, v);
      end
      wr(DRV + 8'(i), 0);
    end

    // R5 R6 R7 R9: edge sweep, all unmasked
    wr(MKA, 0); wr(MKB, 0);
    for (int i = 0; i < 13; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] sa, sg, bitv;
        sa = (i < 7) ? STA : STB;
        bitv = 8'(1 << ((i < 7) ? i : i - 7));
        wr(SNS + 8'(i), 8'(m << 1));
        wr(STA, 8'h7f); wr(STB, 8'h3f);
        @(negedge clk); pin_in[i] = 1;
        settle();
        rd(sa, sg); chk("R6 rising capture", sg, (m >= 2) ? int'(bitv) : 0);
        chk("R9 irq rising", int'(irq), (m >= 2) ? 1 : 0);
        rd(SNS + 8'(i), d); chk("R5 sense readback high", d, (m << 1) | 1);
        wr(sa, bitv);
        rd(sa, sg); chk("R7 clear", sg, 0);
        @(negedge clk); pin_in[i] = 0;
        settle();
        rd(sa, sg); chk("R6 falling capture", sg, (m % 2 == 1) ? int'(bitv) : 0);
        chk("R9 irq falling", int'(irq), (m % 2 == 1) ? 1 : 0);
        rd(SNS + 8'(i), d); chk("R5 sense readback low", d, m << 1);
        wr(sa, 8'h00);
        rd(sa, sg); chk("R7 zero write keeps", sg, (m % 2 == 1) ? int'(bitv) : 0);
        wr(STA, 8'h7f); wr(STB, 8'h3f);
        wr(SNS + 8'(i), 0);
      end
    end

    // R8: edge and clear in the same cycle
    wr(SNS + 8'd2, 8'h04);
    @(negedge clk); pin_in[2] = 1;
    @(negedge clk);
    @(negedge clk); addr = STA; wdata = 8'h04; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd(STA, d); chk("R8 edge beats clear", d, 8'h04);

    // R9: masking a set bit
    wr(MKA, 8'h04);
    @(negedge clk); chk("R9 masked irq", int'(irq), 0);
    wr(MKA, 8'h00);
    @(negedge clk); chk("R9 unmasked irq", int'(irq), 1);
    wr(STA, 8'h7f);
    @(negedge clk); chk("R9 cleared irq", int'(irq), 0);

    // R10: unused bits
    wr(MKA, 8'hff); rd(MKA, d); chk("R10 mask A upper", d, 8'h7f);
    wr(MKB, 8'hff); rd(MKB, d); chk("R10 mask B upper", d, 8'h3f);
    rd(STB, d); chk("R10 status B upper", d, 0);

    // R11: unmapped
    wr(DRV + 8'd12, 8'h15);
    wr(8'h0d, 8'h3f); wr(8'h22, 8'hff); wr(8'hff, 8'hff);
    rd(8'h0d, d); chk("R11 unmapped read", d, 0);
    rd(8'hff, d); chk("R11 unmapped read high", d, 0);
    rd(DRV + 8'd12, d); chk("R11 neighbour unchanged", d, 8'h15);
    rd(MKA, d); chk("R11 mask unchanged", d, 8'h7f);

    // R12: rdata holds without rd_en
    rd(MKB, d);
    @(negedge clk); addr = DRV + 8'd12;
    @(negedge clk); chk("R12 rdata hold", int'(rdata), 8'h3f);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule